// File: doc/BRIEF.md
# Serial Avionics Word Receiver with Label Acceptance

This block receives one channel of a bipolar return-to-zero avionics data bus. The line arrives as two logic signals: one pulses for each "1" bit and the other pulses for each "0" bit. Between bits, and between words, both signals rest low. The receiver recovers the bits using a sample tick that runs at ten times the selected bit rate. A null period of at least four bit times ends a word. The receiver then judges the word: it needs exactly 32 bits, odd overall parity, and no instant at which both lines were high together.

A good word is then looked up by its label, which is the first eight bits received. The lookup uses a 256-entry, one-bit acceptance memory that the host writes. A word that passes both tests replaces the contents of a single-word buffer and raises a new-data flag. The host reads the buffer as a low and a high 16-bit half, and it acknowledges the read with a strobe on the high half. That strobe clears the new-data flag. If a word is stored while the flag is still set, the overrun flag is raised as well. A malformed word is dropped and a one-cycle reject pulse is given.

Top module: `a429_rx_filter`

## Requirements
- R1: After reset, new_o, overrun_o, rej_o, data_lo_o and data_hi_o are all 0, and every label is disabled.
- R2: A pulse on line_hi_i is a 1 bit and a pulse on line_lo_i is a 0 bit. The first bit received lands in bit 0 of the word and the last in bit 31.
- R3: A word ends only after both lines have been low for at least 4 bit times (40 sample ticks). The shorter null between bits inside a word does not end it.
- R4: A well-formed word whose label is enabled is stored. Word bits 15:0 appear on data_lo_o and bits 31:16 on data_hi_o, and new_o is set.
- R5: A well-formed word whose label (word bits 7:0) is disabled is dropped. The buffer, new_o and overrun_o keep their values, and rej_o stays low.
- R6: A word with even overall parity is dropped, and rej_o pulses high for exactly one clock.
- R7: A word with a bit count other than 32 is dropped, and rej_o pulses.
- R8: A word during which both lines were high at the same sample is dropped, and rej_o pulses.
- R9: A one-clock pulse on rd_hi_i clears new_o and overrun_o.
- R10: Storing a word while new_o is set and no rd_hi_i is present overwrites the buffer and sets overrun_o.
- R11: slow_rate_i = 0 selects the fast rate, with a sample tick every DIV_FAST clocks. slow_rate_i = 1 selects the slow rate, with a sample tick every DIV_SLOW clocks. A bit lasts 10 ticks at either rate.
- R12: lbl_we_i writes lbl_data_i into the acceptance entry at lbl_addr_i. A value of 1 enables that label and a value of 0 disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_rate_i | input | 1 | 1 selects the slow bit rate |
| line_hi_i | input | 1 | Line that pulses for each "1" bit |
| line_lo_i | input | 1 | Line that pulses for each "0" bit |
| lbl_we_i | input | 1 | Write strobe for the label acceptance memory |
| lbl_addr_i | input | 8 | Label to write |
| lbl_data_i | input | 1 | Acceptance value to write |
| rd_hi_i | input | 1 | Read acknowledge for the high half |
| data_lo_o | output | 16 | Buffered word, bits 15:0 |
| data_hi_o | output | 16 | Buffered word, bits 31:16 |
| new_o | output | 1 | A stored word has not yet been read |
| overrun_o | output | 1 | A word was stored over an unread one |
| rej_o | output | 1 | One-cycle pulse for a malformed word |

## Verification
The assertions take for granted that rd_hi_i is a strobe of a single clock, and that the words on the line are separated by a full inter-word gap. Under that assumption, a reject pulse is always followed by a low cycle. The bench drives every bit as a pulse of five sample ticks followed by five null ticks, and ends every word with six null bit times. Host strobes are driven only while the line is idle, so they never coincide with a store.

// File: rtl/a429_pkg.sv
package a429_pkg;
  localparam int unsigned WORD_BITS  = 32;
  localparam int unsigned HALF_BITS  = WORD_BITS / 2;
  localparam int unsigned LABEL_BITS = 8;
  localparam int unsigned TICKS_BIT  = 10;
  localparam int unsigned GAP_BITS   = 4;
  localparam int unsigned GAP_TICKS  = TICKS_BIT * GAP_BITS;
  typedef logic [WORD_BITS-1:0]  word_t;
  typedef logic [LABEL_BITS-1:0] label_t;
endpackage

// File: rtl/a429_rate_gen.sv
module a429_rate_gen #(
  parameter int unsigned DIV_FAST = 16,
  parameter int unsigned DIV_SLOW = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(DIV_SLOW + 1);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = slow_i ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= lim) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/a429_bit_rx.sv
module a429_bit_rx
  import a429_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  hi_i,
  input  logic  lo_i,
  output logic  done_o,
  output logic  ok_o,
  output word_t word_o
);
  localparam int unsigned BCW = $clog2(WORD_BITS + 2);
  localparam int unsigned NCW = $clog2(GAP_TICKS + 1);

  logic [1:0]     hi_s, lo_s;
  logic           act_q, bad_q;
  logic [BCW-1:0] bcnt_q;
  logic [NCW-1:0] ncnt_q;
  word_t          sr_q;
  logic           hi, lo, act;

  assign hi  = hi_s[1];
  assign lo  = lo_s[1];
  assign act = hi | lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_s <= '0;
      lo_s <= '0;
    end else begin
      hi_s <= {hi_s[0], hi_i};
      lo_s <= {lo_s[0], lo_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      bad_q  <= 1'b0;
      bcnt_q <= '0;
      ncnt_q <= '0;
      sr_q   <= '0;
      done_o <= 1'b0;
      ok_o   <= 1'b0;
      word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        act_q <= act;
        if (hi && lo) bad_q <= 1'b1;
        if (act) begin
          ncnt_q <= '0;
          if (!act_q) begin
            sr_q <= {hi, sr_q[WORD_BITS-1:1]};
            if (bcnt_q <= BCW'(WORD_BITS)) bcnt_q <= bcnt_q + 1'b1;
          end
        end else if (bcnt_q != '0) begin
          if (ncnt_q == NCW'(GAP_TICKS - 1)) begin
            // gap reached: close the word and judge it
            done_o <= 1'b1;
            ok_o   <= (bcnt_q == BCW'(WORD_BITS)) && (^sr_q) && !bad_q;
            word_o <= sr_q;
            bcnt_q <= '0;
            ncnt_q <= '0;
            bad_q  <= 1'b0;
            sr_q   <= '0;
          end else begin
            ncnt_q <= ncnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/a429_label_mem.sv
module a429_label_mem
  import a429_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  label_t waddr_i,
  input  logic   wdata_i,
  input  label_t raddr_i,
  output logic   hit_o
);
  localparam int unsigned DEPTH = 1 << LABEL_BITS;
  logic [DEPTH-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q[waddr_i] <= wdata_i;
  end

  assign hit_o = en_q[raddr_i];
endmodule

// File: rtl/a429_rx_filter.sv
module a429_rx_filter
  import a429_pkg::*;
#(
  parameter int unsigned DIV_FAST = 16,
  parameter int unsigned DIV_SLOW = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        slow_rate_i,
  input  logic        line_hi_i,
  input  logic        line_lo_i,
  input  logic        lbl_we_i,
  input  logic [7:0]  lbl_addr_i,
  input  logic        lbl_data_i,
  input  logic        rd_hi_i,
  output logic [15:0] data_lo_o,
  output logic [15:0] data_hi_o,
  output logic        new_o,
  output logic        overrun_o,
  output logic        rej_o
);
  logic  tick, word_done, word_ok, label_hit, store;
  word_t word, buf_q;

  a429_rate_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_i(slow_rate_i), .tick_o(tick)
  );

  a429_bit_rx u_bits (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .hi_i(line_hi_i), .lo_i(line_lo_i),
    .done_o(word_done), .ok_o(word_ok), .word_o(word)
  );

  a429_label_mem u_lbl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(lbl_we_i),
    .waddr_i(lbl_addr_i), .wdata_i(lbl_data_i),
    .raddr_i(word[LABEL_BITS-1:0]), .hit_o(label_hit)
  );

  assign store = word_done && word_ok && label_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q     <= '0;
      new_o     <= 1'b0;
      overrun_o <= 1'b0;
      rej_o     <= 1'b0;
    end else begin
      rej_o <= word_done && !word_ok;
      if (store) begin
        buf_q     <= word;
        new_o     <= 1'b1;
        overrun_o <= (new_o && !rd_hi_i) || (overrun_o && !rd_hi_i);
      end else if (rd_hi_i) begin
        new_o     <= 1'b0;
        overrun_o <= 1'b0;
      end
    end
  end

  assign data_lo_o = buf_q[HALF_BITS-1:0];
  assign data_hi_o = buf_q[WORD_BITS-1:HALF_BITS];
endmodule

// File: rtl/a429_rx_chk.sv
module a429_rx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_hi_i,
  input logic [15:0] data_lo_o,
  input logic [15:0] data_hi_o,
  input logic        new_o,
  input logic        overrun_o,
  input logic        rej_o,
  input logic        done_i,
  input logic        ok_i,
  input logic        hit_i
);
  a_r4_data_moves_with_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({data_hi_o, data_lo_o}) |-> new_o);

  a_r5_unlisted_label_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !hit_i) |=> $stable({data_hi_o, data_lo_o}));

  a_r6_rej_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_o |=> !rej_o);

  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !done_i) |=> (!new_o && !overrun_o));

  a_r10_overrun_after_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(new_o));

  a_r10_overrun_implies_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> new_o);

  a_r7_rej_not_with_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ok_i) |=> !rej_o);
endmodule

bind a429_rx_filter a429_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_hi_i(rd_hi_i),
  .data_lo_o(data_lo_o), .data_hi_o(data_hi_o), .new_o(new_o),
  .overrun_o(overrun_o), .rej_o(rej_o),
  .done_i(word_done), .ok_i(word_ok), .hit_i(label_hit)
);

// File: tb/a429_rx_filter_tb.sv
module a429_rx_filter_tb_top;
  localparam int DIV_FAST = 2;
  localparam int DIV_SLOW = 16;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        slow_rate = 1'b0, line_hi = 1'b0, line_lo = 1'b0;
  logic        lbl_we = 1'b0, lbl_data = 1'b0, rd_hi = 1'b0;
  logic [7:0]  lbl_addr = '0;
  logic [15:0] data_lo, data_hi;
  logic        new_f, ovr_f, rej;
  int          n_chk = 0, n_fail = 0, rej_cnt = 0;

  always #4 clk = ~clk;

  a429_rx_filter #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .slow_rate_i(slow_rate),
    .line_hi_i(line_hi), .line_lo_i(line_lo),
    .lbl_we_i(lbl_we), .lbl_addr_i(lbl_addr), .lbl_data_i(lbl_data),
    .rd_hi_i(rd_hi), .data_lo_o(data_lo), .data_hi_o(data_hi),
    .new_o(new_f), .overrun_o(ovr_f), .rej_o(rej)
  );

  always @(posedge clk) if (rej) rej_cnt <= rej_cnt + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [7:0] lbl, logic [22:0] pay);
    logic [31:0] w;
    w = {1'b0, pay, lbl};
    w[31] = ~(^w[30:0]);
    return w;
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // half a bit high, half a bit null; both_at marks a bit driven on both lines
  task automatic send(logic [31:0] w, int nbits, int both_at);
    int half;
    half = 5 * (slow_rate ? DIV_SLOW : DIV_FAST);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      line_hi = (i == both_at) ? 1'b1 : w[i];
      line_lo = (i == both_at) ? 1'b1 : ~w[i];
      idle(half);
      line_hi = 1'b0;
      line_lo = 1'b0;
      idle(half - 1);
    end
    idle(12 * half);
  endtask

  task automatic wr_label(logic [7:0] a, logic v);
    @(negedge clk);
    lbl_we = 1'b1; lbl_addr = a; lbl_data = v;
    @(negedge clk);
    lbl_we = 1'b0;
  endtask

  task automatic read_hi();
    @(negedge clk);
    rd_hi = 1'b1;
    @(negedge clk);
    rd_hi = 1'b0;
    idle(1);
  endtask

  task automatic t_reset();
    check("R1 new", new_f, 0);
    check("R1 overrun", ovr_f, 0);
    check("R1 rej", rej, 0);
    check("R1 data", {data_hi, data_lo}, 0);
  endtask

  task automatic t_accept();
    logic [31:0] w = mk(8'h31, 23'h5A5A5);
    wr_label(8'h31, 1'b1);
    send(w, 32, -1);
    check("R4 data", {data_hi, data_lo}, w);
    check("R2 bit order lo", data_lo, w[15:0]);
    check("R4 new", new_f, 1);
    check("R3 one word", rej_cnt, 0);
  endtask

  task automatic t_read();
    read_hi();
    check("R9 new cleared", new_f, 0);
    check("R9 overrun", ovr_f, 0);
  endtask

  task automatic t_unlisted();
    logic [31:0] keep = {data_hi, data_lo};
    send(mk(8'h55, 23'h12345), 32, -1);
    check("R5 data kept", {data_hi, data_lo}, keep);
    check("R5 new kept", new_f, 0);
    check("R5 no rej", rej_cnt, 0);
  endtask

  task automatic t_bad(string req, logic [31:0] w, int nb, int both, int exp_rej);
    logic [31:0] keep = {data_hi, data_lo};
    send(w, nb, both);
    check(req, {data_hi, data_lo}, keep);
    check(req, new_f, 0);
    check(req, rej_cnt, exp_rej);
  endtask

  task automatic t_overrun();
    logic [31:0] a = mk(8'h31, 23'h00F0F);
    logic [31:0] b = mk(8'h31, 23'h7FFFF);
    send(a, 32, -1);
    check("R10 first new", ovr_f, 0);
    send(b, 32, -1);
    check("R10 overrun", ovr_f, 1);
    check("R10 data newest", {data_hi, data_lo}, b);
    check("R10 hi half", data_hi, b[31:16]);
    read_hi();
    check("R9 overrun cleared", ovr_f, 0);
  endtask

  task automatic t_slow();
    logic [31:0] w = mk(8'hC3, 23'h2AAAA);
    slow_rate = 1'b1;
    wr_label(8'hC3, 1'b1);
    send(w, 32, -1);
    check("R11 slow data", {data_hi, data_lo}, w);
    check("R11 slow new", new_f, 1);
    read_hi();
    slow_rate = 1'b0;
  endtask

  task automatic t_disable();
    logic [31:0] keep = {data_hi, data_lo};
    wr_label(8'h31, 1'b0);
    send(mk(8'h31, 23'h11111), 32, -1);
    check("R12 disabled label", {data_hi, data_lo}, keep);
    check("R12 new", new_f, 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_ni = 1'b1;
    idle(3);
    t_accept();
    t_read();
    t_unlisted();
    t_bad("R6 parity", mk(8'h31, 23'h1) ^ 32'h8000_0000, 32, -1, 1);
    t_bad("R7 length", mk(8'h31, 23'h3), 31, -1, 2);
    t_bad("R8 both high", mk(8'h31, 23'h7), 32, 10, 3);
    t_overrun();
    t_slow();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule